// File: doc/BRIEF.md
# Serial EEPROM Target with Upper-Half Write Lock

This block is a two-wire serial bus target that behaves like a small byte-wide EEPROM. It holds 256 bytes, grouped into 16 pages of 16 bytes, in an internal register array. A host reaches it through a 7-bit device address. The top four bits of that address are fixed, and the low three come from strap pins, so up to eight of these targets can share one bus. The host can write a single byte, write a burst of up to one page, and read from the current position, from a chosen position, or as a running stream.

SCL and SDA come in as plain, oversampled levels. They are resynchronised to the system clock, and START and STOP are recognised as SDA edges while SCL is high. The block pulls SDA low through a single open-drain enable. Written bytes collect in a one-page staging buffer and go to the array only at STOP. A short busy window follows each commit, and during it the target ignores its own address, so the host can poll until the write is done. While a lock input is high, bytes aimed at the upper half of the array are acknowledged but thrown away.

Top module: `eeprom_i2c_target`

## Requirements
- R1: After reset the SDA enable is low, the internal address counter is 0x00, and every byte of the array reads 0xFF.
- R2: The target acknowledges (holds SDA low in the ninth bit) only an address byte equal to binary 1010, then strap[2:0], then the direction bit (0 = write, 1 = read). Any other address byte is not acknowledged, and the rest of that transaction changes nothing.
- R3: A write made of address byte, word address and one data byte stores that byte at the word address when STOP arrives.
- R4: In a burst write, the low 4 bits of the address count up and wrap inside the current 16-byte page. A 17th or later data byte overwrites earlier bytes of the same page, and other pages are untouched.
- R5: While protect_upper is high, data bytes aimed at 0x80 to 0xFF are still acknowledged but not stored. Bytes aimed at 0x00 to 0x7F are stored whatever protect_upper is.
- R6: After a STOP that ends a write carrying at least one data byte, the target acknowledges no address for BUSY_CYCLES clocks. After that window it acknowledges again.
- R7: Each byte sent by the target is the byte at the address counter, and the counter then steps by one across the whole array, from 0xFF to 0x00. A read that starts without a word address begins at the counter.
- R8: A repeated START after the word-address byte, followed by a read address byte, reads from that word address.
- R9: A read continues with the next byte while the host acknowledges. A host non-acknowledge ends it, and the SDA enable stays low from then until the next START.
- R10: Data bytes of a write that ends in a repeated START rather than a STOP are discarded.
- R11: The SDA enable changes only while SCL is low, at SCL high and low phases of four or more clocks. This covers both a 32-clock bit and a 252-clock bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_in | input | 1 | Bus clock level, asynchronous |
| sda_in | input | 1 | Bus data level, asynchronous |
| strap | input | 3 | Low three bits of the device address |
| protect_upper | input | 1 | When high, locks addresses 0x80 to 0xFF against writes |
| sda_pull | output | 1 | When high, the pad pulls SDA low |

## Verification
Every bus edge passes two synchroniser flops and one edge register. The SDA enable therefore moves three clocks after SCL falls at the pins, and a commit lands in the clock after STOP is recognised. The bench's host changes SDA a full quarter-bit after each SCL fall and samples the line a quarter-bit after each SCL rise, so every acknowledge and data bit is read well clear of that three-clock lag. The busy window is polled once while it must still be running and again after BUSY_CYCLES clocks have passed. A per-clock monitor flags any change of the enable after SCL has been high for longer than the synchroniser lag.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int ADDR_W  = 8;
  localparam int PAGE_W  = 4;
  localparam int STRAP_W = 3;
  localparam int HIGH_W  = ADDR_W - PAGE_W;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [7:0]        byte_t;

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} state_t;
  typedef enum logic [1:0] {K_DEV, K_WADDR, K_WDATA} kind_t;

  function automatic logic dev_match(byte_t b, logic [STRAP_W-1:0] s);
    return b[7:1] == {DEV_CODE, s};
  endfunction

  function automatic logic [HIGH_W-1:0] page_of(addr_t a);
    return a[ADDR_W-1:PAGE_W];
  endfunction

  function automatic logic [PAGE_W-1:0] slot_of(addr_t a);
    return a[PAGE_W-1:0];
  endfunction

  function automatic addr_t page_next(addr_t a);
    return {page_of(a), slot_of(a) + PAGE_W'(1)};
  endfunction

  function automatic addr_t arr_next(addr_t a);
    return a + addr_t'(1);
  endfunction

  function automatic logic in_locked_half(addr_t a, logic lock);
    return lock & a[ADDR_W-1];
  endfunction
endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw, cur, prev;
  assign raw = {sda_in, scl_in};

  generate
    for (genvar l = 0; l < LINES; l++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], raw[l]};
      end
      assign cur[l] = chain[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '1;
    else        prev <= cur;
  end

  assign scl_s     = cur[0];
  assign sda_s     = cur[1];
  assign scl_rise  = cur[0] & ~prev[0];
  assign scl_fall  = ~cur[0] & prev[0];
  assign start_det = cur[0] & prev[0] & ~cur[1] & prev[1];
  assign stop_det  = cur[0] & prev[0] & cur[1] & ~prev[1];
endmodule

// File: rtl/eep_page_store.sv
module eep_page_store
  import eep_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_clear,
  input  logic [HIGH_W-1:0] buf_page,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_idx,
  input  byte_t             wr_data,
  input  logic              wr_keep,
  input  logic              commit,
  input  addr_t             rd_addr,
  output byte_t             rd_data
);
  localparam int MEM_BYTES  = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;

  byte_t                 mem  [MEM_BYTES];
  byte_t                 pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask;
  logic [HIGH_W-1:0]     page_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask   <= '0;
      page_q <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= '0;
    end else begin
      if (buf_clear || commit) mask <= '0;
      if (buf_clear) page_q <= buf_page;
      if (wr_en) begin
        pbuf[wr_idx] <= wr_data;
        mask[wr_idx] <= wr_keep;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
    end else if (commit) begin
      for (int i = 0; i < MEM_BYTES; i++)
        if (page_of(addr_t'(i)) == page_q && mask[slot_of(addr_t'(i))])
          mem[i] <= pbuf[slot_of(addr_t'(i))];
    end
  end

  assign rd_data = mem[rd_addr];

  // R10: staging is emptied by every new word address
  p_stage_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    buf_clear |=> (mask == '0));
endmodule

// File: rtl/eep_xfer_ctrl.sv
module eep_xfer_ctrl
  import eep_pkg::*;
#(
  parameter int BUSY_CYCLES = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_s,
  input  logic               sda_s,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic [STRAP_W-1:0] strap,
  input  logic               protect_upper,
  input  byte_t              rd_data,
  output addr_t              ptr,
  output logic               buf_clear,
  output logic [HIGH_W-1:0]  buf_page,
  output logic               wr_en,
  output logic [PAGE_W-1:0]  wr_idx,
  output byte_t              wr_data,
  output logic               wr_keep,
  output logic               commit,
  output logic               sda_pull
);
  localparam int BC_W = $clog2(BUSY_CYCLES + 1);

  state_t          st;
  kind_t           kind;
  logic [3:0]      bit_cnt;
  byte_t           rx_sh, tx_sh;
  logic            rd_mode, pending;
  logic [BC_W-1:0] busy_cnt;

  logic busy, byte_done, dev_done, dev_hit, tx_load, bus_evt;

  assign busy      = busy_cnt != '0;
  assign bus_evt   = start_det | stop_det;
  assign byte_done = (st == ST_RX) && scl_fall && (bit_cnt == 4'd8) && !bus_evt;
  assign dev_done  = byte_done && (kind == K_DEV);
  assign dev_hit   = dev_match(rx_sh, strap) && !busy;
  assign buf_clear = byte_done && (kind == K_WADDR);
  assign buf_page  = page_of(rx_sh);
  assign wr_en     = byte_done && (kind == K_WDATA);
  assign wr_idx    = slot_of(ptr);
  assign wr_data   = rx_sh;
  assign wr_keep   = !in_locked_half(ptr, protect_upper);
  assign commit    = stop_det && pending;
  assign tx_load   = scl_fall && !bus_evt &&
                     (((st == ST_ACK) && rd_mode) || (st == ST_MACK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      kind     <= K_DEV;
      bit_cnt  <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      rd_mode  <= 1'b0;
      pending  <= 1'b0;
      ptr      <= '0;
      sda_pull <= 1'b0;
    end else if (start_det) begin
      st       <= ST_RX;
      kind     <= K_DEV;
      bit_cnt  <= '0;
      rd_mode  <= 1'b0;
      pending  <= 1'b0;
      sda_pull <= 1'b0;
    end else if (stop_det) begin
      st       <= ST_IDLE;
      pending  <= 1'b0;
      sda_pull <= 1'b0;
    end else if (tx_load) begin
      tx_sh    <= rd_data;
      sda_pull <= ~rd_data[7];
      ptr      <= arr_next(ptr);
      bit_cnt  <= '0;
      st       <= ST_TX;
    end else begin
      case (st)
        ST_RX: begin
          if (scl_rise) begin
            rx_sh   <= {rx_sh[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (byte_done) begin
            case (kind)
              K_DEV: begin
                if (dev_hit) begin
                  st       <= ST_ACK;
                  sda_pull <= 1'b1;
                  rd_mode  <= rx_sh[0];
                  kind     <= K_WADDR;
                end else begin
                  st <= ST_IDLE;
                end
              end
              K_WADDR: begin
                ptr      <= rx_sh;
                st       <= ST_ACK;
                sda_pull <= 1'b1;
                kind     <= K_WDATA;
              end
              default: begin
                ptr      <= page_next(ptr);
                pending  <= 1'b1;
                st       <= ST_ACK;
                sda_pull <= 1'b1;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            sda_pull <= 1'b0;
            bit_cnt  <= '0;
            st       <= ST_RX;
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall) begin
            if (bit_cnt == 4'd8) begin
              sda_pull <= 1'b0;
              st       <= ST_MACK;
            end else begin
              sda_pull <= ~tx_sh[6];
              tx_sh    <= {tx_sh[6:0], 1'b0};
            end
          end
        end
        ST_MACK: begin
          if (scl_rise && sda_s) st <= ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_cnt <= '0;
    else if (commit) busy_cnt <= BC_W'(BUSY_CYCLES);
    else if (busy)   busy_cnt <= busy_cnt - BC_W'(1);
  end

  // R2: a foreign address byte is never acknowledged
  p_nack_foreign_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_done && !dev_match(rx_sh, strap)) |=> !sda_pull);

  // R6: own address ignored while the write cycle runs
  p_busy_nack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_done && busy) |=> !sda_pull);

  // R6: a commit opens the busy window
  p_busy_after_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> busy);

  // R4: burst writes stay on their page
  p_page_stays_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (page_of(ptr) == $past(page_of(ptr))));

  // R7: every byte sent advances the counter by one
  p_read_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> (ptr == $past(ptr) + addr_t'(1)));

  // R11: the pull-down only moves while SCL is low
  p_pull_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_s);
endmodule

// File: rtl/eeprom_i2c_target.sv
module eeprom_i2c_target
  import eep_pkg::*;
#(
  parameter int BUSY_CYCLES = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_in,
  input  logic               sda_in,
  input  logic [STRAP_W-1:0] strap,
  input  logic               protect_upper,
  output logic               sda_pull
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic buf_clear, wr_en, wr_keep, commit;
  logic [HIGH_W-1:0] buf_page;
  logic [PAGE_W-1:0] wr_idx;
  byte_t wr_data, rd_data;
  addr_t ptr;

  eep_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  eep_xfer_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .strap(strap), .protect_upper(protect_upper), .rd_data(rd_data),
    .ptr(ptr), .buf_clear(buf_clear), .buf_page(buf_page),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_keep(wr_keep),
    .commit(commit), .sda_pull(sda_pull)
  );

  eep_page_store i_store (
    .clk(clk), .rst_n(rst_n), .buf_clear(buf_clear), .buf_page(buf_page),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_keep(wr_keep),
    .commit(commit), .rd_addr(ptr), .rd_data(rd_data)
  );
endmodule

// File: tb/test_eeprom_i2c_target.sv
module test_eeprom_i2c_target;
  localparam int BUSY = 400;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, scl_m, sda_m, prot, sda_pull, sda_line;
  assign sda_line = sda_m & ~sda_pull;

  eeprom_i2c_target #(.BUSY_CYCLES(BUSY)) i_eeprom_i2c_target (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .strap(STRAP), .protect_upper(prot), .sda_pull(sda_pull)
  );

  int total = 0, bad = 0, q = 8, hi_run = 0, pull_viol = 0;
  logic pull_q = 1'b0;
  logic [7:0] model [256];
  logic [7:0] mptr;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-clock monitor of the pull-down against SCL
  always @(negedge clk) begin
    if (rst_n) begin
      hi_run = scl_m ? hi_run + 1 : 0;
      if (sda_pull !== pull_q && hi_run > 3) pull_viol++;
    end
    pull_q = sda_pull;
  end

  task automatic bus_start();
    sda_m = 1'b1; tick(q); scl_m = 1'b1; tick(q);
    sda_m = 1'b0; tick(q); scl_m = 1'b0; tick(q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(q); scl_m = 1'b1; tick(q); sda_m = 1'b1; tick(q);
  endtask

  task automatic clock_bit(input logic b, output logic seen);
    sda_m = b; tick(q); scl_m = 1'b1; tick(q);
    seen = sda_line; tick(q); scl_m = 1'b0; tick(q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
    clock_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic recv_byte(input logic host_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin clock_bit(1'b1, s); b[i] = s; end
    clock_bit(!host_ack, s);
  endtask

  task automatic settle();
    tick(BUSY + 20);
  endtask

  task automatic wr_txn(input string req, input logic [7:0] a, input int n,
                        input logic [7:0] first, input logic [7:0] step);
    logic ack;
    logic [7:0] d;
    logic [7:0] pb [16];
    logic [15:0] keep = '0;
    bus_start();
    send_byte(DEV_W, ack); check(req, "address ack", ack, 1);
    send_byte(a, ack);     check(req, "word ack", ack, 1);
    mptr = a;
    for (int i = 0; i < n; i++) begin
      d = 8'(first + i * step);
      send_byte(d, ack); check(req, "data ack", ack, 1);
      pb[mptr[3:0]] = d;
      keep[mptr[3:0]] = !(prot && mptr[7]);
      mptr = {mptr[7:4], mptr[3:0] + 4'd1};
    end
    bus_stop();
    for (int i = 0; i < 16; i++)
      if (keep[i]) model[{a[7:4], 4'(i)}] = pb[i];
  endtask

  task automatic rd_txn(input string req, input logic pick, input logic [7:0] a,
                        input int n);
    logic ack;
    logic [7:0] d;
    bus_start();
    if (pick) begin
      send_byte(DEV_W, ack); check(req, "address ack", ack, 1);
      send_byte(a, ack);     check(req, "word ack", ack, 1);
      mptr = a;
      bus_start();
    end
    send_byte(DEV_R, ack); check(req, "read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, d);
      check(req, $sformatf("byte at %0h", mptr), d, model[mptr]);
      mptr = mptr + 8'd1;
    end
    bus_stop();
    check("R9", "pull released after host nack", sda_pull, 0);
  endtask

  task automatic poll(input string req, input logic exp_ack);
    logic ack;
    bus_start();
    send_byte(DEV_W, ack); check(req, "poll ack", ack, exp_ack);
    bus_stop();
  endtask

  initial begin : main
    logic ack;
    logic [7:0] d;
    for (int i = 0; i < 256; i++) model[i] = 8'hFF;
    mptr = 8'h00;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; prot = 1'b0;
    tick(5); rst_n = 1'b1; tick(5);
    check("R1", "pull after reset", sda_pull, 0);

    // R1 / R7: current read from reset counter
    rd_txn("R1", 1'b0, 8'h00, 1);

    // R2: foreign strap and foreign code ignored
    bus_start();
    send_byte({4'b1010, ~STRAP, 1'b0}, ack); check("R2", "strap mismatch", ack, 0);
    send_byte(8'h60, ack); send_byte(8'h33, ack);
    bus_stop();
    bus_start();
    send_byte({4'b1011, STRAP, 1'b0}, ack); check("R2", "code mismatch", ack, 0);
    send_byte(8'h61, ack); send_byte(8'h34, ack);
    bus_stop();
    tick(20);
    rd_txn("R2", 1'b1, 8'h60, 2);

    // R3 + R8: single byte then random read
    wr_txn("R3", 8'h10, 1, 8'hA5, 8'h00);
    settle();
    rd_txn("R8", 1'b1, 8'h10, 1);

    // R4: 20-byte burst from 0x2C wraps in page 0x20
    wr_txn("R4", 8'h2C, 20, 8'h40, 8'h01);
    settle();
    rd_txn("R4", 1'b1, 8'h20, 17);

    // R5: lock high, upper dropped, lower kept
    prot = 1'b1;
    wr_txn("R5", 8'h80, 3, 8'hC0, 8'h01); settle();
    wr_txn("R5", 8'h40, 2, 8'h70, 8'h01); settle();
    rd_txn("R5", 1'b1, 8'h80, 3);
    rd_txn("R5", 1'b1, 8'h40, 2);
    prot = 1'b0;
    wr_txn("R5", 8'h81, 1, 8'hC7, 8'h00);

    // R6: poll inside and after the busy window
    poll("R6", 1'b0);
    tick(BUSY);
    poll("R6", 1'b1);
    rd_txn("R5", 1'b1, 8'h81, 1);

    // R7: wrap across the top of the array, then current read
    rd_txn("R7", 1'b1, 8'hFE, 4);
    rd_txn("R7", 1'b0, 8'h00, 1);

    // R10: data then repeated start is discarded
    bus_start();
    send_byte(DEV_W, ack); send_byte(8'h50, ack); send_byte(8'h11, ack);
    mptr = 8'h51;
    bus_start();
    send_byte(DEV_R, ack); check("R10", "read after restart ack", ack, 1);
    recv_byte(1'b0, d); check("R10", "byte after restart", d, model[mptr]);
    mptr = mptr + 8'd1;
    bus_stop();
    poll("R10", 1'b1);
    rd_txn("R10", 1'b1, 8'h50, 1);

    // R11: slow bus timing, 252 clocks per bit
    q = 63;
    wr_txn("R11", 8'h05, 1, 8'h5A, 8'h00);
    settle();
    rd_txn("R11", 1'b1, 8'h05, 1);
    q = 8;
    check("R11", "pull moved with SCL high", pull_viol, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    tick(190000);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule